// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block sits behind an instruction byte stream and turns an addressing byte, plus any displacement bytes that follow it, into a memory address. A one-cycle `start_i` strobe arms it. It then takes the addressing byte over a valid/ready handshake and reads the base register through a read port into an eight-entry register file. Next it takes zero, one or four displacement bytes, least significant byte first, and adds them to the base. It closes the operation with a one-cycle `done_o` pulse. The result outputs hold their values until the next operation.

The addressing byte carries three fields. Bits 7:6 select the mode, bits 5:3 hold a field passed through to the opcode logic, and bits 2:0 name a register. Register-direct operands and encodings that would need a scale-index byte produce no address. The first raises a flag. The second raises an error.

Top module: `modrm_ea_gen`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `byte_ready_o`, `err_o`, `reg_direct_o` are 0 and `ea_o`, `reg_field_o`, `rm_o` are 0.
- R2: From the accepted addressing byte, bits 5:3 appear unchanged on `reg_field_o` and bits 2:0 appear on `rm_o`. Both are valid while `done_o` is high and are held afterwards.
- R3: For mode 00 (bits 7:6) with rm other than 100 and 101, `ea_o` equals the register named by rm and no displacement byte is taken. `done_o` rises two cycles after the addressing byte is accepted.
- R4: For mode 00 with rm 101, four displacement bytes are taken and `ea_o` is their value, with the first byte in bits 7:0. No register contributes to the address.
- R5: For mode 01, one displacement byte is taken, sign-extended and added to the register named by rm (0xff subtracts 1).
- R6: For mode 10, four displacement bytes are taken, least significant first, and added to the register named by rm.
- R7: The address sum wraps modulo 2^32.
- R8: For mode 11, `reg_direct_o` is 1, `err_o` is 0, `ea_o` is 0 and no displacement byte is taken. `done_o` rises one cycle after the addressing byte is accepted.
- R9: For rm 100 under modes 00, 01 or 10, `err_o` is 1, `reg_direct_o` is 0, `ea_o` is 0 and no displacement byte is taken. `done_o` rises one cycle after the addressing byte is accepted.
- R10: `done_o` is high for exactly one cycle. In displacement modes it is high in the cycle after the last displacement byte is accepted.
- R11: `byte_ready_o` is high only while the block waits for the addressing byte or a displacement byte. Bytes offered while it is low are not taken, and `start_i` has no effect while an operation is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms the block for one operation when idle |
| byte_i | input | 8 | Instruction stream byte |
| byte_valid_i | input | 1 | `byte_i` holds a byte |
| byte_ready_o | output | 1 | Block takes `byte_i` this cycle if valid |
| rf_idx_o | output | 3 | Register file read index |
| rf_data_i | input | 32 | Register file read data for `rf_idx_o` |
| ea_o | output | 32 | Effective address |
| reg_field_o | output | 3 | Pass-through middle field of the addressing byte |
| rm_o | output | 3 | Register field of the addressing byte |
| reg_direct_o | output | 1 | Operand is a register, not memory |
| err_o | output | 1 | Encoding needs a scale-index byte (unsupported) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A displacement counter that is off by one shows up at the ports within the same operation. The block either takes a byte too many or too few, which is visible as a wrong `done_o` cycle and a wrong accepted-byte count, or it places a byte in the wrong lane of `ea_o`. A wrong sign extension or base latch shows only in `ea_o` at the `done_o` pulse. For that reason every one of the 256 addressing-byte values is swept, and a full sweep of displacement-byte values is run through the sign-extending mode. A stuck state machine shows one cycle later as `byte_ready_o` still high after `done_o`, or as a missing second pulse on the next operation.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {MOD_IND = 2'b00, MOD_D8 = 2'b01, MOD_D32 = 2'b10, MOD_REG = 2'b11} mod_e;

  typedef struct packed {
    mod_e       mode;
    logic [2:0] reg_f;
    logic [2:0] rm;
  } modrm_t;

  localparam logic [2:0] RM_SIB = 3'b100;
  localparam logic [2:0] RM_ABS = 3'b101;

  typedef enum logic [1:0] {ST_IDLE, ST_MODRM, ST_BASE, ST_DISP} state_e;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
#(
  parameter int DISP_BYTES = 4,
  parameter int LEN_W      = 3
) (
  input  modrm_t           fld_i,
  output logic             direct_o,
  output logic             err_o,
  output logic             abs_o,
  output logic [LEN_W-1:0] len_o
);
  assign direct_o = (fld_i.mode == MOD_REG);
  assign err_o    = !direct_o && (fld_i.rm == RM_SIB);
  assign abs_o    = (fld_i.mode == MOD_IND) && (fld_i.rm == RM_ABS);

  always_comb begin
    unique case (fld_i.mode)
      MOD_IND: len_o = abs_o ? LEN_W'(DISP_BYTES) : '0;
      MOD_D8:  len_o = LEN_W'(1);
      MOD_D32: len_o = LEN_W'(DISP_BYTES);
      default: len_o = '0;
    endcase
  end
endmodule

// File: rtl/eag_disp_collect.sv
module eag_disp_collect #(
  parameter int DISP_BYTES = 4,
  parameter int LEN_W      = 3,
  localparam int CNT_W     = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1,
  localparam int DW        = 8 * DISP_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [7:0]       byte_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DW-1:0]    disp_o,   // includes the byte being loaded
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_o = load_i && (LEN_W'(cnt_q) == len_i - LEN_W'(1));

  for (genvar g = 0; g < DISP_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       hit;
    assign hit = load_i && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q <= '0;
      else if (clear_i) lane_q <= '0;
      else if (hit)     lane_q <= byte_i;
    end
    assign disp_o[8*g +: 8] = hit ? byte_i : lane_q;
  end
endmodule

// File: rtl/eag_adder.sv
module eag_adder #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic              short_i,  // only byte 0 valid, sign-extend it
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] ext;
  assign ext  = short_i ? {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]} : disp_i;
  assign ea_o = base_i + ext;  // wraps modulo 2^ADDR_W
endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic [2:0]        rf_idx_o,
  input  logic [ADDR_W-1:0] rf_data_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [2:0]        reg_field_o,
  output logic [2:0]        rm_o,
  output logic              reg_direct_o,
  output logic              err_o,
  output logic              done_o
);
  localparam int DISP_BYTES = ADDR_W / 8;
  localparam int LEN_W      = $clog2(DISP_BYTES + 1);

  state_e            state_q;
  modrm_t            fld_q, fld_in;
  logic              dir_q, err_q, abs_q, done_q;
  logic              dir_d, err_d, abs_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] base_q, ea_q, ea_sum, disp_next;
  logic              take, last_byte;

  assign fld_in       = modrm_t'(byte_i);
  assign byte_ready_o = (state_q == ST_MODRM) || (state_q == ST_DISP);
  assign take         = byte_valid_i && byte_ready_o;

  eag_decode #(.DISP_BYTES(DISP_BYTES), .LEN_W(LEN_W)) u_dec (
    .fld_i   (fld_in),
    .direct_o(dir_d),
    .err_o   (err_d),
    .abs_o   (abs_d),
    .len_o   (len_d)
  );

  eag_disp_collect #(.DISP_BYTES(DISP_BYTES), .LEN_W(LEN_W)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i((state_q == ST_MODRM) && take),
    .load_i ((state_q == ST_DISP) && take),
    .byte_i (byte_i),
    .len_i  (len_q),
    .disp_o (disp_next),
    .last_o (last_byte)
  );

  eag_adder #(.ADDR_W(ADDR_W)) u_add (
    .base_i (base_q),
    .disp_i (disp_next),
    .short_i(fld_q.mode == MOD_D8),
    .ea_o   (ea_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fld_q   <= modrm_t'('0);
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
      abs_q   <= 1'b0;
      len_q   <= '0;
      base_q  <= '0;
      ea_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_MODRM;
        ST_MODRM: if (take) begin
          fld_q <= fld_in;
          dir_q <= dir_d;
          err_q <= err_d;
          abs_q <= abs_d;
          len_q <= len_d;
          if (dir_d || err_d) begin
            ea_q    <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_BASE;
          end
        end
        ST_BASE: begin
          base_q <= abs_q ? '0 : rf_data_i;
          if (len_q == '0) begin
            ea_q    <= rf_data_i;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_DISP;
          end
        end
        ST_DISP: if (take && last_byte) begin
          ea_q    <= ea_sum;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_idx_o     = fld_q.rm;
  assign ea_o         = ea_q;
  assign reg_field_o  = fld_q.reg_f;
  assign rm_o         = fld_q.rm;
  assign reg_direct_o = dir_q;
  assign err_o        = err_q;
  assign done_o       = done_q;

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_from_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q) != ST_IDLE);

  a_r11_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_ready_o);

  a_r8_direct_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && reg_direct_o) |-> (ea_o == '0 && !err_o));

  a_r9_err_sib: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rm_o == RM_SIB && ea_o == '0 && !reg_direct_o));
endmodule

// File: tb/tb_modrm_ea_gen.sv
`timescale 1ns/1ps
module tb_modrm_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  bdata = '0;
  logic        bvalid = 1'b0;
  logic        bready;
  logic [2:0]  rf_idx;
  logic [31:0] rf_data, ea;
  logic [2:0]  reg_f, rm;
  logic        direct, err, done;
  logic [31:0] rf [8];

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign rf_data = rf[rf_idx];

  modrm_ea_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_i(bdata),
    .byte_valid_i(bvalid), .byte_ready_o(bready), .rf_idx_o(rf_idx),
    .rf_data_i(rf_data), .ea_o(ea), .reg_field_o(reg_f), .rm_o(rm),
    .reg_direct_o(direct), .err_o(err), .done_o(done)
  );

  always @(posedge clk) if (bvalid && bready) accepted++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_op(input logic [7:0] m, input logic [31:0] d, input int gap, input bit poke);
    logic [1:0]  md;
    logic [2:0]  r;
    logic [31:0] exp_ea;
    int nb, exp_k, k, acc0;
    string tag;
    md = m[7:6];
    r  = m[2:0];
    nb = 0; exp_k = 1; exp_ea = '0; tag = "R8";
    if (md == 2'b11) begin
      tag = "R8";
    end else if (r == 3'b100) begin
      tag = "R9";
    end else if (md == 2'b00 && r == 3'b101) begin
      nb = 4; exp_ea = d; tag = "R4";
    end else if (md == 2'b00) begin
      exp_k = 2; exp_ea = rf[r]; tag = "R3";
    end else if (md == 2'b01) begin
      nb = 1; exp_ea = rf[r] + {{24{d[7]}}, d[7:0]}; tag = "R5";
    end else begin
      nb = 4; exp_ea = rf[r] + d; tag = "R6";
    end
    acc0 = accepted;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    bdata = m; bvalid = 1'b1;
    while (!bready) @(negedge clk);
    @(negedge clk) bvalid = 1'b0;
    k = 1;
    if (nb > 0) begin
      for (int g = 0; g < gap; g++) begin
        start = poke;  // ignored while busy (R11)
        bdata = 8'hee; // offered with valid low: not taken (R11)
        @(negedge clk);
      end
      start = 1'b0;
      for (int i = 0; i < nb; i++) begin
        bdata = d[8*i +: 8]; bvalid = 1'b1;
        while (!bready) @(negedge clk);
        @(negedge clk) bvalid = 1'b0;
      end
      k = 1;
    end
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(done && k == exp_k, "R10 done timing", 32'(k), 32'(exp_k));
    chk(ea == exp_ea, tag, ea, exp_ea);
    chk(reg_f == m[5:3] && rm == r, "R2 fields", {26'b0, reg_f, rm}, {26'b0, m[5:3], r});
    chk(direct == (md == 2'b11), "R8 direct flag", 32'(direct), 32'(md == 2'b11));
    chk(err == (md != 2'b11 && r == 3'b100), "R9 error flag", 32'(err), 32'(md != 2'b11 && r == 3'b100));
    chk(!bready, "R11 ready low at done", 32'(bready), 32'd0);
    chk(accepted - acc0 == nb + 1, "R11 byte count", 32'(accepted - acc0), 32'(nb + 1));
    @(negedge clk);
    chk(!done, "R10 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 32'h1357_9bdf * (i + 1) + 32'h40;
    repeat (3) @(negedge clk);
    chk(!done && !bready && !err && !direct && ea == '0 && reg_f == '0 && rm == '0,
        "R1 reset state", ea, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !bready && ea == '0, "R1 after release", {31'b0, bready}, 32'd0);

    // every addressing byte
    for (int m = 0; m < 256; m++)
      run_op(8'(m), 32'h9e37_79b9 * (m + 1), m % 3, m[0]);

    // every short displacement value, sign extension (R5)
    for (int v = 0; v < 256; v++) run_op(8'h41, {24'hcccccc, 8'(v)}, v % 2, 1'b0);

    // wraparound (R7)
    rf[2] = 32'hffff_fffe;
    run_op(8'h42, 32'h0000_0003, 0, 1'b0);
    chk(ea == 32'h1, "R7 short wrap", ea, 32'h1);
    rf[6] = 32'h0000_0010;
    run_op(8'h86, 32'hffff_fff0, 1, 1'b1);
    chk(ea == 32'h0, "R7 long wrap to zero", ea, 32'h0);
    rf[5] = 32'h8000_0000;
    run_op(8'h85, 32'h8000_0001, 0, 1'b0);
    chk(ea == 32'h1, "R7 long wrap", ea, 32'h1);
    // absolute ignores register contents (R4)
    rf[5] = 32'hdead_beef;
    run_op(8'h05, 32'h0000_0060, 2, 1'b1);
    chk(ea == 32'h60, "R4 absolute", ea, 32'h60);

    // start while idle but no byte offered: ready rises, nothing taken (R11)
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(bready, "R11 ready waiting for byte", 32'(bready), 32'd1);
    run_op(8'hd8, 32'h0, 0, 1'b0);

    summary();
  end
endmodule